// File: doc/BRIEF.md
# Strided Vector Memory Access Unit

This block moves one vector between a vector register file and a memory made of sixteen interleaved banks. A single start command supplies a base word address, a signed stride and an element count. The unit then walks the elements in order, forming the address of element i as base plus i times stride, one element per clock where the banks allow it. The low four address bits choose the bank. The remaining bits choose the word inside that bank.

After an access, a bank needs four cycles to recover. Each bank has its own recovery counter. When the next element's bank is still recovering, the address stream holds that element and issues nothing until the bank is free. Strides that hit the same bank on consecutive elements, such as zero or any multiple of sixteen, therefore run at one element every four cycles. Strides that spread the elements across the banks run at one element per cycle.

A store takes each element's data from the vector register read port in the cycle that element issues. A load delivers each word to the vector register write port exactly twelve cycles after issue, tagged with its element index. Because elements issue in order, the words arrive in order. A one-cycle done pulse closes every command.

Top module: `vlsu_top`

## Requirements
- R1: The bank of an access is address bits [3:0] and the word inside the bank is bits [9:4]; `req_bank` always equals the low four bits of `req_addr` for the reported access.
- R2: Element i is accessed at word address (base + i*stride) modulo 1024, where `stride` is a two's-complement signed value.
- R3: An element issues in the first cycle, after the previous element's cycle, in which its bank has been idle for at least 4 cycles since its last access. With no conflict the rate is one element per cycle. Stride 0 or any multiple of 16 gives exactly 4 cycles between issues.
- R4: A stalled element is held rather than skipped. Elements issue in strictly increasing index order, every index 0 to length-1 exactly once.
- R5: `req_fire` is high in the cycle after an element issues. For a load, that element's `vr_we` is high exactly 11 cycles after its `req_fire`, which is 12 cycles after issue.
- R6: Load writebacks come in element order. `vr_idx` carries the element index and `vr_data` carries the memory word at that element's address.
- R7: A store writes `elem_rd_data`, read at index `elem_rd_idx` in the issue cycle, to the element's address. A later load of that address returns it.
- R8: The length is 0 to 64 elements, and a value above 64 acts as 64. Length 0 issues nothing and pulses `done` in the cycle after the start.
- R9: `done` is a single-cycle pulse. For a store it comes in the same cycle as the last element's `req_fire`. For a load it comes one cycle after the last `vr_we`.
- R10: `busy` is high from the cycle after an accepted start with nonzero length until `done`, and is low while `done` is high. A `start` presented while `busy` is high has no effect on addresses, count or data.
- R11: After reset, `busy`, `done`, `req_fire` and `vr_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (accepted only when idle) |
| op_store | input | 1 | 1 = store, 0 = load |
| base_addr | input | 10 | First element word address |
| stride | input | 10 | Signed element stride in words |
| vec_len | input | 7 | Element count (values above 64 act as 64) |
| busy | output | 1 | Command in progress |
| elem_rd_idx | output | 6 | Vector register read index for store data |
| elem_rd_data | input | 64 | Store data for `elem_rd_idx` |
| req_fire | output | 1 | An element issued in the previous cycle |
| req_addr | output | 10 | Word address of that element |
| req_bank | output | 4 | Bank of that element |
| vr_we | output | 1 | Vector register write enable (loads) |
| vr_idx | output | 6 | Element index for the write |
| vr_data | output | 64 | Loaded word |
| done | output | 1 | Command complete pulse |

## Verification
A stuck or miscounted bank recovery counter shows at once in the `req_fire` spacing. The stall comes either a cycle early or late, or on the wrong bank, so the measured issue cycles drift away from the arithmetic schedule on the first conflicting element. A wrong address accumulator or sign extension shows in `req_addr` on the second element of a negative-stride run. A shortened or lengthened return pipeline moves every `vr_we` away from the 11-cycle offset after its `req_fire`. A bad element counter or end detection shows as a wrong issue count or a misplaced `done` when the command finishes.

// File: rtl/vlsu_pkg.sv
package vlsu_pkg;
  localparam int DEF_BANK_REST = 4;
  localparam int DEF_LOAD_LAT  = 12;

  typedef enum logic { OP_LOAD = 1'b0, OP_STORE = 1'b1 } vlsu_op_e;
endpackage

// File: rtl/vlsu_agen.sv
module vlsu_agen #(
  parameter int AW = 10,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_cmd,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic [LW:0]   count,
  input  logic          hold,
  output logic          active,
  output logic [AW-1:0] cur_addr,
  output logic [LW-1:0] cur_idx,
  output logic          is_last
);
  logic [AW-1:0] step_q;
  logic [LW:0]   count_q;

  assign is_last = ({1'b0, cur_idx} == count_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cur_addr <= '0;
      cur_idx  <= '0;
      step_q   <= '0;
      count_q  <= '0;
    end else if (load_cmd) begin
      active   <= (count != '0);
      cur_addr <= base;
      cur_idx  <= '0;
      step_q   <= step;
      count_q  <= count;
    end else if (active && !hold) begin
      cur_addr <= cur_addr + step_q;
      cur_idx  <= cur_idx + 1'b1;
      if (is_last) active <= 1'b0;
    end
  end
endmodule

// File: rtl/vlsu_bank_timers.sv
module vlsu_bank_timers #(
  parameter int BB   = 4,
  parameter int REST = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [BB-1:0] hit_bank,
  input  logic [BB-1:0] ask_bank,
  output logic          ask_busy
);
  localparam int NB = 1 << BB;
  localparam int CW = (REST > 2) ? $clog2(REST) : 1;

  logic [NB-1:0] recovering;

  for (genvar b = 0; b < NB; b++) begin : g_timer
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst)                              cnt <= '0;
      else if (hit && hit_bank == BB'(b))   cnt <= CW'(REST - 1);
      else if (cnt != '0)                   cnt <= cnt - 1'b1;
    end
    assign recovering[b] = (cnt != '0);
  end

  assign ask_busy = recovering[ask_bank];
endmodule

// File: rtl/vlsu_bank_array.sv
module vlsu_bank_array #(
  parameter int AW  = 10,
  parameter int BB  = 4,
  parameter int DW  = 64,
  parameter int LW  = 6,
  parameter int LAT = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_en,
  input  logic          acc_we,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  input  logic [LW-1:0] acc_idx,
  output logic          ret_valid,
  output logic [LW-1:0] ret_idx,
  output logic [DW-1:0] ret_data
);
  localparam int NB  = 1 << BB;
  localparam int WPB = 1 << (AW - BB);

  logic [DW-1:0] rd_bus [NB];
  logic [BB-1:0] bank_q;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] mem [WPB];
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (acc_en && acc_addr[BB-1:0] == BB'(b)) begin
        if (acc_we) mem[acc_addr[AW-1:BB]] <= acc_wdata;
        rd_q <= mem[acc_addr[AW-1:BB]];
      end
    end
    assign rd_bus[b] = rd_q;
  end

  logic [LAT-1:0] vld_q;
  logic [LW-1:0]  idx_q [LAT];
  logic [DW-1:0]  dat_q [LAT-1];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[LAT-2:0], acc_en & ~acc_we};
  end

  always_ff @(posedge clk) begin
    bank_q   <= acc_addr[BB-1:0];
    idx_q[0] <= acc_idx;
    dat_q[0] <= rd_bus[bank_q];
    for (int k = 1; k < LAT; k++) idx_q[k] <= idx_q[k-1];
    for (int k = 1; k < LAT-1; k++) dat_q[k] <= dat_q[k-1];
  end

  assign ret_valid = vld_q[LAT-1];
  assign ret_idx   = idx_q[LAT-1];
  assign ret_data  = dat_q[LAT-2];
endmodule

// File: rtl/vlsu_top.sv
module vlsu_top #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 64,
  parameter int BANK_BITS = 4,
  parameter int MAX_VL    = 64,
  parameter int BANK_REST = vlsu_pkg::DEF_BANK_REST,
  parameter int LOAD_LAT  = vlsu_pkg::DEF_LOAD_LAT,
  localparam int LW       = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_store,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LW:0]       vec_len,
  output logic              busy,
  output logic [LW-1:0]     elem_rd_idx,
  input  logic [DATA_W-1:0] elem_rd_data,
  output logic              req_fire,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BANK_BITS-1:0] req_bank,
  output logic              vr_we,
  output logic [LW-1:0]     vr_idx,
  output logic [DATA_W-1:0] vr_data,
  output logic              done
);
  import vlsu_pkg::*;

  logic              start_acc;
  logic [LW:0]       len_eff, len_q;
  vlsu_op_e          st_q;
  logic              act, last, bank_wait, issue;
  logic [ADDR_W-1:0] cur_addr;
  logic [LW-1:0]     cur_idx;
  logic              wb_valid;
  logic [LW-1:0]     wb_idx;
  logic [DATA_W-1:0] wb_data;
  logic              ld_end, done_nxt;

  assign len_eff   = (vec_len > (LW+1)'(MAX_VL)) ? (LW+1)'(MAX_VL) : vec_len;
  assign start_acc = start && !busy;
  assign issue     = act && !bank_wait;

  vlsu_agen #(.AW(ADDR_W), .LW(LW)) u_agen (
    .clk(clk), .rst(rst), .load_cmd(start_acc), .base(base_addr), .step(stride),
    .count(len_eff), .hold(bank_wait), .active(act), .cur_addr(cur_addr),
    .cur_idx(cur_idx), .is_last(last)
  );

  vlsu_bank_timers #(.BB(BANK_BITS), .REST(BANK_REST)) u_timers (
    .clk(clk), .rst(rst), .hit(issue), .hit_bank(cur_addr[BANK_BITS-1:0]),
    .ask_bank(cur_addr[BANK_BITS-1:0]), .ask_busy(bank_wait)
  );

  vlsu_bank_array #(.AW(ADDR_W), .BB(BANK_BITS), .DW(DATA_W), .LW(LW), .LAT(LOAD_LAT)) u_banks (
    .clk(clk), .rst(rst), .acc_en(issue), .acc_we(st_q == OP_STORE), .acc_addr(cur_addr),
    .acc_wdata(elem_rd_data), .acc_idx(cur_idx), .ret_valid(wb_valid),
    .ret_idx(wb_idx), .ret_data(wb_data)
  );

  assign elem_rd_idx = cur_idx;
  assign vr_we       = wb_valid;
  assign vr_idx      = wb_idx;
  assign vr_data     = wb_data;

  assign ld_end   = wb_valid && (st_q == OP_LOAD) && ({1'b0, wb_idx} == len_q - 1'b1);
  assign done_nxt = (start_acc && len_eff == '0) || (issue && st_q == OP_STORE && last) || ld_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      req_fire <= 1'b0;
      st_q     <= OP_LOAD;
      len_q    <= '0;
      req_addr <= '0;
      req_bank <= '0;
    end else begin
      done     <= done_nxt;
      req_fire <= issue;
      req_addr <= cur_addr;
      req_bank <= cur_addr[BANK_BITS-1:0];
      if (start_acc) begin
        st_q  <= op_store ? OP_STORE : OP_LOAD;
        len_q <= len_eff;
      end
      if (start_acc && len_eff != '0) busy <= 1'b1;
      else if (done_nxt)              busy <= 1'b0;
    end
  end
endmodule

// File: rtl/vlsu_checks.sv
module vlsu_checks #(
  parameter int BB = 4,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          req_fire,
  input logic [BB-1:0] req_bank,
  input logic          vr_we,
  input logic [LW-1:0] vr_idx,
  input logic          done,
  input logic          busy,
  input logic          st_op
);
  logic [LW-1:0] next_wb;

  always_ff @(posedge clk) begin
    if (rst || done) next_wb <= '0;
    else if (vr_we)  next_wb <= next_wb + 1'b1;
  end

  AST_BANK_REST_1: assert property (@(posedge clk) disable iff (rst)
    req_fire && $past(req_fire) |-> req_bank != $past(req_bank)); // R3
  AST_BANK_REST_2: assert property (@(posedge clk) disable iff (rst)
    req_fire && $past(req_fire, 2) |-> req_bank != $past(req_bank, 2)); // R3
  AST_BANK_REST_3: assert property (@(posedge clk) disable iff (rst)
    req_fire && $past(req_fire, 3) |-> req_bank != $past(req_bank, 3)); // R3
  AST_WB_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    vr_we |-> vr_idx == next_wb); // R6
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (rst)
    vr_we |-> $past(req_fire && !st_op, 11)); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
endmodule

bind vlsu_top vlsu_checks #(.BB(BANK_BITS), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .req_fire(req_fire), .req_bank(req_bank), .vr_we(vr_we),
  .vr_idx(vr_idx), .done(done), .busy(busy), .st_op(st_q == vlsu_pkg::OP_STORE)
);

// File: tb/sim_vlsu_top.sv
module sim_vlsu_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, op_store = 1'b0;
  logic [9:0] base_addr = '0, stride = '0;
  logic [6:0] vec_len = '0;
  logic busy, req_fire, vr_we, done;
  logic [5:0] elem_rd_idx, vr_idx;
  logic [63:0] elem_rd_data, vr_data;
  logic [9:0] req_addr;
  logic [3:0] req_bank;

  logic [63:0] src [64];
  logic [63:0] bmem [1024];
  bit          bwr  [1024];
  int checks = 0, errors = 0, cycles = 0;

  assign elem_rd_data = src[elem_rd_idx];

  always #(CLK_P/2) clk = ~clk;

  vlsu_top u0 (
    .clk(clk), .rst(rst), .start(start), .op_store(op_store), .base_addr(base_addr),
    .stride(stride), .vec_len(vec_len), .busy(busy), .elem_rd_idx(elem_rd_idx),
    .elem_rd_data(elem_rd_data), .req_fire(req_fire), .req_addr(req_addr),
    .req_bank(req_bank), .vr_we(vr_we), .vr_idx(vr_idx), .vr_data(vr_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit st, input int base, input int strd, input int vl,
                        input bit disturb, input int seed);
    int es[64], ea[64], fr[16];
    int fn[64], fa[64], fb[64], wn[64], wi[64];
    logic [63:0] wd[64];
    int nel, prev, nf, nw, nd, dn, exp_done, endn, a;
    bit busy0, busyd;
    nel = (vl > 64) ? 64 : vl;
    for (int b = 0; b < 16; b++) fr[b] = 0;
    prev = 0;
    for (int i = 0; i < nel; i++) begin
      a = (((base + i*strd) % 1024) + 1024) % 1024;
      ea[i] = a;
      es[i] = (prev + 1 > fr[a % 16]) ? prev + 1 : fr[a % 16];
      fr[a % 16] = es[i] + 4;
      prev = es[i];
      src[i] = {32'(seed), 32'(i * 7 + 3)};
    end
    if (nel == 0) exp_done = 0;
    else if (st)  exp_done = es[nel-1];
    else          exp_done = es[nel-1] + 12;
    endn = exp_done + 6;
    nf = 0; nw = 0; nd = 0; dn = -1; busy0 = 0; busyd = 1;
    op_store = st; base_addr = 10'(base); stride = 10'(strd); vec_len = 7'(vl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n <= endn; n++) begin
      if (n == 0) busy0 = busy;
      if (req_fire && nf < 64) begin fn[nf] = n; fa[nf] = int'(req_addr); fb[nf] = int'(req_bank); nf++; end
      if (vr_we && nw < 64) begin wn[nw] = n; wi[nw] = int'(vr_idx); wd[nw] = vr_data; nw++; end
      if (done) begin nd++; if (dn < 0) begin dn = n; busyd = busy; end end
      if (disturb && n == 2) begin
        op_store = ~st; base_addr = 10'd513; stride = 10'd7; vec_len = 7'd5; start = 1'b1;
      end
      if (disturb && n == 3) start = 1'b0;
      @(negedge clk);
    end
    chk(nf == nel, "R8", "issue count", nf, nel);
    for (int i = 0; i < nel && i < nf; i++) begin
      chk(fa[i] == ea[i], "R2", "element address", fa[i], ea[i]);
      chk(fb[i] == ea[i] % 16, "R1", "bank select", fb[i], ea[i] % 16);
      chk(fn[i] == es[i], "R3 R4", "issue cycle", fn[i], es[i]);
    end
    chk(nd == 1 && dn == exp_done, "R9", "done cycle", dn, exp_done);
    chk(busy0 == (nel != 0) && busyd == 0, "R10", "busy window", {busy0, busyd}, {nel != 0, 1'b0});
    if (disturb) chk(nf == nel && fa[nel-1] == ea[nel-1], "R10", "start while busy ignored", fa[nel-1], ea[nel-1]);
    if (st) begin
      chk(nw == 0, "R7", "no writeback on store", nw, 0);
      for (int i = 0; i < nel; i++) begin bmem[ea[i]] = src[i]; bwr[ea[i]] = 1'b1; end
    end else begin
      chk(nw == nel, "R6", "writeback count", nw, nel);
      for (int i = 0; i < nel && i < nw; i++) begin
        chk(wi[i] == i, "R6", "writeback index", wi[i], i);
        chk(wn[i] == es[i] + 11, "R5", "load latency", wn[i], es[i] + 11);
        if (bwr[ea[i]]) chk(wd[i] == bmem[ea[i]], "R6 R7", "load data", wd[i], bmem[ea[i]]);
      end
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) bwr[i] = 1'b0;
    for (int i = 0; i < 64; i++) src[i] = '0;
    repeat (5) @(negedge clk);
    chk({busy, done, req_fire, vr_we} == 4'b0, "R11", "reset outputs",
        {busy, done, req_fire, vr_we}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    run_op(1, 0,    1,  64, 0, 1);   // unit-stride store
    run_op(0, 0,    1,  64, 0, 0);   // unit-stride load
    run_op(1, 200,  16, 10, 0, 2);   // one bank, every 4 cycles
    run_op(0, 200,  16, 10, 0, 0);
    run_op(0, 5,    0,  6,  0, 0);   // stride zero
    run_op(1, 20,  -3,  30, 0, 3);   // negative stride with wrap
    run_op(0, 20,  -3,  30, 0, 0);
    run_op(1, 400,  8,  12, 0, 4);   // two banks alternate
    run_op(0, 400,  8,  12, 0, 0);
    run_op(1, 600,  2,  40, 1, 5);   // start while busy
    run_op(0, 600,  2,  40, 1, 0);
    run_op(0, 0,    1,  0,  0, 0);   // zero length
    run_op(1, 700,  1,  100, 0, 6);  // length clamp
    run_op(0, 700,  1,  64, 0, 0);
    run_op(0, 0,    5,  12, 0, 0);
    run_op(0, 704, -32, 20, 0, 0);   // multiple of 16, negative
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule